// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host port and an external asynchronous static RAM of 262,144 sixteen-bit words. The host offers one read or write at a time with a valid/ready handshake, giving an 18-bit word address, 16-bit write data and a 2-bit lane mask (bit 0 enables data bits 7:0, bit 1 enables bits 15:8). The controller generates the memory strobes from a state machine whose dwell times are clock-cycle counts, and it returns a one-cycle `done` pulse that carries the read word for reads.

The memory is selected only while `sram_cs_n` is low and `sram_cs` is high. Between accesses every strobe sits at its inactive level (standby). The data bus is presented as a split pair, `sram_dq_o` with enable `sram_dq_oe` and the returned `sram_dq_i`, so that the pad-level three-state buffer stays outside the block. All memory-side outputs come straight from flops.

States: `ST_IDLE` (standby, ready), `ST_RD_ACC` (read strobes held for `RD_CYC` cycles), `ST_WR_SETUP` (one cycle with the address and selects valid and write enable high), `ST_WR_PULSE` (write enable low and bus driven for `WP_CYC` cycles), `ST_WR_REC` (write enable high again, `WC_CYC-WP_CYC-1` cycles), and `ST_RECOV` (standby hold-off of `RD_TURN` cycles after a read or `WR_TURN` after a write). Transitions: IDLE to RD_ACC or WR_SETUP on an accepted request; RD_ACC to RECOV when its count expires, capturing the data; WR_SETUP to WR_PULSE to WR_REC to RECOV as each count expires; RECOV to IDLE when its count expires.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, and whenever `req_ready` is high, the memory is in standby: `sram_cs_n`=1, `sram_cs`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_lb_n`=1, `sram_ub_n`=1, `sram_dq_oe`=0.
- R2: `req_ready` is high only in the idle state; a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after.
- R3: A read holds `sram_cs_n`=0, `sram_cs`=1, `sram_oe_n`=0 and `sram_we_n`=1 for `RD_CYC` cycles (default 7); `sram_lb_n` is low exactly when mask bit 0 is set and `sram_ub_n` exactly when mask bit 1 is set.
- R4: A read's `done` rises `RD_CYC` clock edges after the accepting edge, and `rdata` holds the word present on `sram_dq_i` at the end of the access, with the byte of each disabled lane forced to zero.
- R5: A write spends one set-up cycle with the selects and lanes active and `sram_we_n` high, then holds `sram_we_n` low for exactly `WP_CYC` cycles (default 5), then recovers; its `done` rises `WC_CYC` edges (default 7) after the accepting edge.
- R6: `sram_dq_oe` is high only while `sram_we_n` is low and `sram_oe_n` is high, and it is high for every cycle of the write pulse, carrying the request's write data.
- R7: A write changes only the byte lanes whose mask bit is set; the other byte of the stored word is kept.
- R8: After a read's `done`, `req_ready` returns `RD_TURN` edges later (default 3); after a write's `done`, `WR_TURN` edges later (default 1), so a read that follows a write always has at least one deselected cycle before its output enable falls.
- R9: While the memory is selected, `sram_addr`, `sram_lb_n` and `sram_ub_n` stay constant and equal to the values taken with the request.
- R10: `done` is a single-cycle pulse, one per accepted request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, valid with `done` after a read |
| sram_addr | output | 18 | Memory address |
| sram_cs_n | output | 1 | First chip select, active low |
| sram_cs | output | 1 | Second chip select, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_lb_n | output | 1 | Low byte lane enable, active low |
| sram_ub_n | output | 1 | High byte lane enable, active low |
| sram_dq_o | output | 16 | Data to the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
The assertions assume that reset is held long enough to clear the state register and that the host never changes a request in the cycle it is accepted; they do not depend on what the memory returns on `sram_dq_i`. The stimulus drives requests only at falling edges, waits for `req_ready` before raising `req_valid`, and drops it right after the accepting edge. A memory model in the bench drives stale data until a read's strobes have been held for the full access count and refuses writes whose pulse is short or whose bus was not driven, so timing faults show up as wrong read data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC,
        ST_RECOV
    } st_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic we_n;
        logic lb_n;
        logic ub_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_STANDBY = '{
        cs_n:  1'b1,
        cs:    1'b0,
        oe_n:  1'b1,
        we_n:  1'b1,
        lb_n:  1'b1,
        ub_n:  1'b1,
        dq_oe: 1'b0
    };

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int RD_CYC  = 7,
    parameter int WP_CYC  = 5,
    parameter int WC_CYC  = 7,
    parameter int RD_TURN = 3,
    parameter int WR_TURN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output st_e  state_q,
    output st_e  state_d,
    output logic accept,
    output logic rd_finish,
    output logic wr_finish
);

    localparam int REC_CYC = WC_CYC - WP_CYC - 1;
    localparam int MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int MAX_B   = (RD_TURN > WR_TURN) ? RD_TURN : WR_TURN;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL = (MAX_C > REC_CYC) ? MAX_C : REC_CYC;
    localparam int CW      = $clog2(MAX_ALL + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        rd_finish = 1'b0;
        wr_finish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = '0;
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_zero) begin
                    state_d   = ST_RECOV;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(RD_TURN - 1);
                    rd_finish = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WP_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(REC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (tmr_zero) begin
                    state_d   = ST_RECOV;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(WR_TURN - 1);
                    wr_finish = 1'b1;
                end
            end
            ST_RECOV: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/asram_strobe.sv
module asram_strobe
    import asram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  st_e        state_d,
    input  logic [1:0] mask_nxt,
    output strobe_t    strobe_q
);

    strobe_t strobe_d;

    always_comb begin
        strobe_d = STROBE_STANDBY;
        unique case (state_d)
            ST_RD_ACC: begin
                strobe_d.cs_n = 1'b0;
                strobe_d.cs   = 1'b1;
                strobe_d.oe_n = 1'b0;
                strobe_d.lb_n = ~mask_nxt[0];
                strobe_d.ub_n = ~mask_nxt[1];
            end
            ST_WR_SETUP, ST_WR_REC: begin
                strobe_d.cs_n = 1'b0;
                strobe_d.cs   = 1'b1;
                strobe_d.lb_n = ~mask_nxt[0];
                strobe_d.ub_n = ~mask_nxt[1];
            end
            ST_WR_PULSE: begin
                strobe_d.cs_n  = 1'b0;
                strobe_d.cs    = 1'b1;
                strobe_d.we_n  = 1'b0;
                strobe_d.dq_oe = 1'b1;
                strobe_d.lb_n  = ~mask_nxt[0];
                strobe_d.ub_n  = ~mask_nxt[1];
            end
            default: begin
                strobe_d = STROBE_STANDBY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= STROBE_STANDBY;
        end else begin
            strobe_q <= strobe_d;
        end
    end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int AW    = 18,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             rd_finish,
    input  logic             wr_finish,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    input  logic [DW-1:0]    dq_in,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic [LANES-1:0] mask_nxt,
    output logic [DW-1:0]    rdata_q,
    output logic             done_q
);

    localparam int LW = DW / LANES;

    logic [LANES-1:0] mask_q;
    logic [DW-1:0]    rd_masked;

    assign mask_nxt = accept ? req_mask : mask_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_masked[g*LW +: LW] = mask_q[g] ? dq_in[g*LW +: LW] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= rd_finish | wr_finish;
            if (rd_finish) begin
                rdata_q <= rd_masked;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 16,
    parameter int LANES   = 2,
    parameter int RD_CYC  = 7,
    parameter int WP_CYC  = 5,
    parameter int WC_CYC  = 7,
    parameter int RD_TURN = 3,
    parameter int WR_TURN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    sram_addr,
    output logic             sram_cs_n,
    output logic             sram_cs,
    output logic             sram_oe_n,
    output logic             sram_we_n,
    output logic             sram_lb_n,
    output logic             sram_ub_n,
    output logic [DW-1:0]    sram_dq_o,
    output logic             sram_dq_oe,
    input  logic [DW-1:0]    sram_dq_i
);

    st_e              state_q;
    st_e              state_d;
    logic             accept;
    logic             rd_finish;
    logic             wr_finish;
    logic [LANES-1:0] mask_nxt;
    strobe_t          strobe_q;

    asram_fsm #(
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .WC_CYC  (WC_CYC),
        .RD_TURN (RD_TURN),
        .WR_TURN (WR_TURN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .state_q   (state_q),
        .state_d   (state_d),
        .accept    (accept),
        .rd_finish (rd_finish),
        .wr_finish (wr_finish)
    );

    asram_datapath #(
        .AW    (AW),
        .DW    (DW),
        .LANES (LANES)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .rd_finish (rd_finish),
        .wr_finish (wr_finish),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .dq_in     (sram_dq_i),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_o),
        .mask_nxt  (mask_nxt),
        .rdata_q   (rdata),
        .done_q    (done)
    );

    asram_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_d  (state_d),
        .mask_nxt (mask_nxt[1:0]),
        .strobe_q (strobe_q)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign sram_cs_n  = strobe_q.cs_n;
    assign sram_cs    = strobe_q.cs;
    assign sram_oe_n  = strobe_q.oe_n;
    assign sram_we_n  = strobe_q.we_n;
    assign sram_lb_n  = strobe_q.lb_n;
    assign sram_ub_n  = strobe_q.ub_n;
    assign sram_dq_oe = strobe_q.dq_oe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int AW     = 18,
    parameter int WP_CYC = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic [AW-1:0] sram_addr,
    input logic          sram_cs_n,
    input logic          sram_cs,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic          sram_lb_n,
    input logic          sram_ub_n,
    input logic          sram_dq_oe
);

    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!sram_we_n) begin
            we_low_cnt <= we_low_cnt + 16'd1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    a_r1_standby_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && !sram_cs && sram_oe_n && sram_we_n
                       && sram_lb_n && sram_ub_n && !sram_dq_oe));

    a_r3_read_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_cs_n && sram_cs && sram_we_n));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == 16'(WP_CYC)));

    a_r6_drive_only_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && sram_oe_n));

    a_r6_pulse_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_dq_oe);

    a_r8_gap_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> $past(sram_cs_n));

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> ($stable(sram_addr)
            && $stable(sram_lb_n) && $stable(sram_ub_n)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .AW     (AW),
    .WP_CYC (WP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_cs    (sram_cs),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_lb_n  (sram_lb_n),
    .sram_ub_n  (sram_ub_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

    localparam int RD_CYC  = 7;
    localparam int WP_CYC  = 5;
    localparam int WC_CYC  = 7;
    localparam int RD_TURN = 3;
    localparam int WR_TURN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        done;
    logic [15:0] rdata;
    logic [17:0] sram_addr;
    logic        sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i;

    always #5 clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .done(done), .rdata(rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_cs(sram_cs),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model
    logic [15:0] mem_m [logic [17:0]];
    logic [15:0] shadow [logic [17:0]];
    logic [15:0] m_dq = 16'hDEAD;
    int          rd_run = 0;
    int          wr_run = 0;
    logic [15:0] wbuf;
    logic [1:0]  wlanes;
    bit          wok;
    logic [17:0] waddr;
    wire         sel = !sram_cs_n && sram_cs;

    assign sram_dq_i = m_dq;

    function automatic logic [15:0] mget(input logic [17:0] a);
        return mem_m.exists(a) ? mem_m[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] sget(input logic [17:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_run = 0;
            wr_run = 0;
            m_dq <= 16'hDEAD;
        end else begin
            if (sram_dq_oe && !sram_oe_n)
                chk(1'b0, "R6 bus driven while output enable low", 32'(sram_dq_oe), 0);
            if (sel && !sram_oe_n && sram_we_n) begin
                rd_run = rd_run + 1;
                if (rd_run >= RD_CYC - 1)
                    m_dq <= {sram_ub_n ? 8'hA5 : mget(sram_addr)[15:8],
                             sram_lb_n ? 8'h5A : mget(sram_addr)[7:0]};
                else
                    m_dq <= 16'hDEAD;
            end else begin
                rd_run = 0;
                m_dq <= 16'hDEAD;
            end
            if (sel && !sram_we_n) begin
                if (wr_run == 0) wok = 1'b1;
                wr_run = wr_run + 1;
                wok    = wok && sram_dq_oe;
                wbuf   = sram_dq_o;
                wlanes = {~sram_ub_n, ~sram_lb_n};
                waddr  = sram_addr;
            end else if (wr_run != 0) begin
                logic [15:0] nw;
                chk(wr_run == WP_CYC, "R5 write pulse length", 32'(wr_run), WP_CYC);
                chk(wok, "R6 bus driven through write pulse", 32'(wok), 1);
                nw = mget(waddr);
                if (wlanes[0]) nw[7:0]  = wbuf[7:0];
                if (wlanes[1]) nw[15:8] = wbuf[15:8];
                mem_m[waddr] = nw;
                wr_run = 0;
            end
        end
    end

    // scoreboard
    typedef struct {
        bit          wr;
        logic [17:0] a;
        logic [15:0] exp;
        logic [1:0]  m;
        int          acc;
    } item_t;

    item_t sb[$];
    bit    prev_done = 1'b0;
    bit    turn_pend = 1'b0;
    int    turn_start = 0;
    int    turn_exp = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(done && prev_done), "R10 done lasts one cycle", 32'(done), 0);
            if (!sram_cs_n && sb.size() > 0) begin
                chk(sram_addr == sb[0].a, "R9 address during access", 32'(sram_addr), 32'(sb[0].a));
                chk({~sram_ub_n, ~sram_lb_n} == sb[0].m, "R3 lane enables match mask",
                    32'({~sram_ub_n, ~sram_lb_n}), 32'(sb[0].m));
            end
            if (req_ready)
                chk(sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && sram_lb_n
                    && sram_ub_n && !sram_dq_oe, "R1 standby while ready",
                    32'({sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe}),
                    32'b1011110);
            if (turn_pend && req_ready) begin
                chk(cyc - turn_start == turn_exp, "R8 recovery before ready",
                    32'(cyc - turn_start), 32'(turn_exp));
                turn_pend = 1'b0;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 done without request", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.wr) begin
                        chk(cyc - it.acc == WC_CYC, "R5 write latency", 32'(cyc - it.acc), WC_CYC);
                        turn_exp = WR_TURN;
                    end else begin
                        chk(cyc - it.acc == RD_CYC, "R4 read latency", 32'(cyc - it.acc), RD_CYC);
                        chk(rdata == it.exp, "R4 R7 read data", 32'(rdata), 32'(it.exp));
                        turn_exp = RD_TURN;
                    end
                    turn_pend  = 1'b1;
                    turn_start = cyc;
                end
            end
            prev_done = done;
        end
    end

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        item_t it;
        logic [15:0] s;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        it.wr = wr;
        it.a  = a;
        it.m  = m;
        s = sget(a);
        if (wr) begin
            if (m[0]) s[7:0]  = d[7:0];
            if (m[1]) s[15:8] = d[15:8];
            shadow[a] = s;
            it.exp = 16'h0;
        end else begin
            it.exp = {m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00};
        end
        @(posedge clk);
        @(negedge clk);
        it.acc = cyc;
        sb.push_back(it);
        chk(!req_ready, "R2 ready low after accept", 32'(req_ready), 0);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = 16'hFFFF;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready && sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe && !done,
            "R1 reset state", 32'({req_ready, sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe, done}),
            32'b1101100);
        rst_n = 1'b1;
        // full word write and read
        access(1, 18'h00010, 16'h1234, 2'b11);
        access(0, 18'h00010, 16'h0, 2'b11);
        // top address, low lane only
        access(1, 18'h3FFFF, 16'hABCD, 2'b01);
        access(0, 18'h3FFFF, 16'h0, 2'b11);
        // high lane only over it (R7)
        access(1, 18'h3FFFF, 16'h7700, 2'b10);
        access(0, 18'h3FFFF, 16'h0, 2'b11);
        access(0, 18'h3FFFF, 16'h0, 2'b10);
        access(0, 18'h3FFFF, 16'h0, 2'b01);
        // no lanes enabled: read returns zero, write changes nothing
        access(1, 18'h00010, 16'hFFFF, 2'b00);
        access(0, 18'h00010, 16'h0, 2'b00);
        access(0, 18'h00010, 16'h0, 2'b11);
        // unwritten word
        access(0, 18'h20000, 16'h0, 2'b11);
        // pattern sweep, alternating write and read
        for (int i = 0; i < 16; i++) begin
            access(1, 18'(i * 4099), 16'(16'h0101 * i ^ 16'hC3A5), 2'(i % 4));
            access(0, 18'(i * 4099), 16'h0, 2'b11);
        end
        // back-to-back reads, then writes
        for (int i = 0; i < 8; i++) access(0, 18'(i * 4099), 16'h0, 2'(3 - i % 4));
        for (int i = 0; i < 4; i++) access(1, 18'(100 + i), 16'(16'h8001 << i), 2'b11);
        for (int i = 0; i < 4; i++) access(0, 18'(100 + i), 16'h0, 2'b11);
        repeat (20) @(negedge clk);
        chk(sb.size() == 0, "R10 every request completed", 32'(sb.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule